// File: doc/BRIEF.md
# Cascadable Serial-In Latched Output Driver

This block takes a serial bit stream and turns it into eight gated drive-enable bits. Each rising edge of the shift clock moves the stream one position along an 8-bit shift chain. A separate latch clock copies the whole chain into an 8-bit holding register. The holding register feeds the eight drive outputs, which an active-low enable can force off. A drive bit at 1 means that the load's sink is switched on.

The last stage of the chain also appears on a cascade output. This output is retimed to the falling edge of the shift clock, so a downstream copy of the block, fed from it, gets half a shift period of extra hold margin even when its clock arrives late. Chains of any length can be built this way. One active-low clear resets the chain, the holding register and the cascade flop together, without waiting for a clock.

Top module: `serial_latch_driver`

## Requirements
- R1: On each rising edge of `shift_clk`, `ser_in` enters chain bit 0 and every chain bit i moves to bit i+1, with bit 7 discarded.
- R2: On each rising edge of `latch_clk`, all eight chain bits are copied into the holding register. The holding register, and so `drive`, keeps its value while the chain shifts without a latch edge.
- R3: While `clear_n` is low, the chain, the holding register and `cascade_out` are zero at once, without a clock. Clock edges during the clear have no effect.
- R4: While `oe_n` is 1, all eight `drive` bits are 0, whatever the holding register contains.
- R5: While `oe_n` is 0, `drive[i]` equals holding-register bit i, with 1 meaning load i is sunk (on) and 0 meaning off. The first bit shifted in of eight ends in bit 7.
- R6: `cascade_out` carries chain bit 7 and changes only on a falling edge of `shift_clk`. After a rising edge that changes bit 7, the old value stays on the output until the next falling edge.
- R7: When `shift_clk` and `latch_clk` rise together, the holding register captures the chain contents from before that edge, which is one stage behind the new chain.
- R8: When two blocks are chained through `cascade_out` into `ser_in`, and the second shift clock is skewed later by less than half a period, 16 shifted bits arrive intact. After a common latch, the second block holds the first eight bits and the first block holds the last eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock. The rising edge shifts the chain and the falling edge updates the cascade output |
| latch_clk | input | 1 | Latch clock. The rising edge copies the chain into the holding register |
| clear_n | input | 1 | Asynchronous clear of all state, active low |
| oe_n | input | 1 | Output enable, active low. At 1 it forces all drives off |
| ser_in | input | 1 | Serial data input |
| drive | output | 8 | Drive-enable bits, where 1 means the sink is on |
| cascade_out | output | 1 | Retimed copy of chain bit 7, for the next stage |

## Verification
The chain reaction is due at the first rising shift edge, and the bench samples it only after a latch edge has moved it onto `drive`. `drive` then holds the new holding value half a period after that latch edge and responds to `oe_n` and `clear_n` with no clock at all. `cascade_out` is due one half period after the rising edge, at the falling edge. The bench samples it twice: between the rising and falling edges, where it must still show the old value, and after the falling edge, where it must show the new one. Every sample is taken in the middle of a clock phase, away from any edge. Clear and enable changes are made only while both clocks are steady.

// File: rtl/sld_pkg.sv
package sld_pkg;
    // Default chain length used by every stage of the driver
    localparam int unsigned SLD_BITS = 8;
    // Half-period hold gain of the cascade path, in clock phases
    localparam int unsigned SLD_CASCADE_PHASES = 1;
endpackage

// File: rtl/sld_shift_stage.sv
module sld_shift_stage #(
    parameter int unsigned BITS = sld_pkg::SLD_BITS
) (
    input  logic            clk,
    input  logic            clear_n,
    input  logic            ser_in,
    output logic [BITS-1:0] par_out,
    output logic            tail_out
);
    localparam int unsigned TOP = BITS - 1;

    typedef struct packed {
        logic [BITS-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;
    logic   tail_d, tail_q;

    // next chain: new bit at position 0, everything moves up by one
    always_comb begin
        chain_d      = chain_q;
        chain_d.bits = {chain_q.bits[TOP-1:0], ser_in};
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) chain_q <= '0;
        else          chain_q <= chain_d;
    end

    // cascade copy of the last stage, retimed to the falling edge
    always_comb tail_d = chain_q.bits[TOP];

    always_ff @(negedge clk or negedge clear_n) begin
        if (!clear_n) tail_q <= 1'b0;
        else          tail_q <= tail_d;
    end

    assign par_out  = chain_q.bits;
    assign tail_out = tail_q;

    // ---------------- assertions ----------------
    logic rise_seen_q, fall_seen_q;

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) rise_seen_q <= 1'b0;
        else          rise_seen_q <= 1'b1;
    end

    always_ff @(negedge clk or negedge clear_n) begin
        if (!clear_n) fall_seen_q <= 1'b0;
        else          fall_seen_q <= 1'b1;
    end

    assert_shift_R1: assert property (@(posedge clk) disable iff (!clear_n)
        rise_seen_q |-> (chain_q.bits == {$past(chain_q.bits[TOP-1:0]), $past(ser_in)}));

    assert_cascade_R6: assert property (@(negedge clk) disable iff (!clear_n)
        fall_seen_q |-> (tail_q == $past(chain_q.bits[TOP])));

    assert_clear_chain_R3: assert property (@(posedge clk)
        !clear_n |-> (chain_q.bits == '0 && tail_q == 1'b0));
endmodule

// File: rtl/sld_store_stage.sv
module sld_store_stage #(
    parameter int unsigned BITS = sld_pkg::SLD_BITS
) (
    input  logic            clk,
    input  logic            clear_n,
    input  logic [BITS-1:0] par_in,
    output logic [BITS-1:0] par_out
);
    typedef struct packed {
        logic [BITS-1:0] held;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d      = hold_q;
        hold_d.held = par_in;
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) hold_q <= '0;
        else          hold_q <= hold_d;
    end

    assign par_out = hold_q.held;

    // ---------------- assertions ----------------
    logic latch_seen_q;

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) latch_seen_q <= 1'b0;
        else          latch_seen_q <= 1'b1;
    end

    assert_latch_R2: assert property (@(posedge clk) disable iff (!clear_n)
        latch_seen_q |-> (hold_q.held == $past(par_in)));

    assert_clear_hold_R3: assert property (@(posedge clk)
        !clear_n |-> (hold_q.held == '0));
endmodule

// File: rtl/sld_out_gate.sv
module sld_out_gate #(
    parameter int unsigned BITS = sld_pkg::SLD_BITS
) (
    input  logic            oe_n,
    input  logic [BITS-1:0] held,
    output logic [BITS-1:0] drive
);
    for (genvar i = 0; i < BITS; i++) begin : g_lane
        always_comb drive[i] = held[i] & ~oe_n;
    end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
    parameter int unsigned BITS = sld_pkg::SLD_BITS
) (
    input  logic            shift_clk,
    input  logic            latch_clk,
    input  logic            clear_n,
    input  logic            oe_n,
    input  logic            ser_in,
    output logic [BITS-1:0] drive,
    output logic            cascade_out
);
    logic [BITS-1:0] chain_bits;
    logic [BITS-1:0] held_bits;

    sld_shift_stage #(.BITS(BITS)) u_shift (
        .clk      (shift_clk),
        .clear_n  (clear_n),
        .ser_in   (ser_in),
        .par_out  (chain_bits),
        .tail_out (cascade_out)
    );

    sld_store_stage #(.BITS(BITS)) u_store (
        .clk     (latch_clk),
        .clear_n (clear_n),
        .par_in  (chain_bits),
        .par_out (held_bits)
    );

    sld_out_gate #(.BITS(BITS)) u_gate (
        .oe_n  (oe_n),
        .held  (held_bits),
        .drive (drive)
    );

    // ---------------- assertions ----------------
    assert_gate_off_R4: assert property (@(posedge latch_clk)
        oe_n |-> (drive == '0));

    assert_gate_off_shift_R4: assert property (@(posedge shift_clk)
        oe_n |-> (drive == '0));
endmodule

// File: tb/serial_latch_driver_test.sv
module serial_latch_driver_test;
    localparam int CLK_PERIOD = 8;     // 125 MHz
    localparam int HALF = CLK_PERIOD / 2;
    localparam int SKEW = 2;

    logic       shift_clk, shift_clk2, latch_clk, clear_n, oe_n, ser_in;
    logic [7:0] drive, drive2;
    logic       cascade_out, cascade2;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    serial_latch_driver uut (
        .shift_clk(shift_clk), .latch_clk(latch_clk), .clear_n(clear_n),
        .oe_n(oe_n), .ser_in(ser_in), .drive(drive), .cascade_out(cascade_out)
    );

    serial_latch_driver downstream (
        .shift_clk(shift_clk2), .latch_clk(latch_clk), .clear_n(clear_n),
        .oe_n(oe_n), .ser_in(cascade_out), .drive(drive2), .cascade_out(cascade2)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_shift(input logic b);
        ser_in = b;
        #HALF shift_clk = 1'b1;
        #HALF shift_clk = 1'b0;
    endtask

    task automatic pulse_latch();
        #HALF latch_clk = 1'b1;
        #HALF latch_clk = 1'b0;
        #1;
    endtask

    task automatic shift_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) pulse_shift(v[i]);
    endtask

    task automatic do_clear();
        #1 clear_n = 1'b0;
        #HALF clear_n = 1'b1;
        #1;
    endtask

    task automatic test_reset();
        oe_n = 1'b0;
        #1;
        check("R3 reset drive", drive, 8'h00);
        check("R3 reset cascade", {7'b0, cascade_out}, 8'h00);
    endtask

    task automatic test_load(input logic [7:0] v);
        oe_n = 1'b0;
        shift_byte(v);
        pulse_latch();
        check("R1 R5 shifted byte on drive", drive, v);
    endtask

    task automatic test_hold_without_latch();
        shift_byte(8'hC3);
        #1;
        check("R2 drive holds during shift", drive, 8'h3C);
        pulse_latch();
        check("R2 latch copies chain", drive, 8'hC3);
    endtask

    task automatic test_enable();
        oe_n = 1'b1;
        #1;
        check("R4 disabled drive off", drive, 8'h00);
        shift_byte(8'hFF);
        pulse_latch();
        check("R4 disabled after latch", drive, 8'h00);
        oe_n = 1'b0;
        #1;
        check("R5 enabled follows holding", drive, 8'hFF);
    endtask

    task automatic test_cascade_timing();
        do_clear();
        pulse_shift(1'b1);
        for (int i = 0; i < 6; i++) pulse_shift(1'b0);
        ser_in = 1'b0;
        #HALF shift_clk = 1'b1;
        #(HALF/2);
        check("R6 cascade unchanged after rise", {7'b0, cascade_out}, 8'h00);
        #(HALF/2) shift_clk = 1'b0;
        #1;
        check("R6 cascade updated after fall", {7'b0, cascade_out}, 8'h01);
        pulse_latch();
        check("R5 first bit lands in bit 7", drive, 8'h80);
    endtask

    task automatic test_tied_clocks();
        oe_n = 1'b0;
        shift_byte(8'h96);
        ser_in = 1'b1;
        #HALF begin shift_clk = 1'b1; latch_clk = 1'b1; end
        #HALF begin shift_clk = 1'b0; latch_clk = 1'b0; end
        #1;
        check("R7 tied clocks capture old chain", drive, 8'h96);
        pulse_latch();
        check("R7 chain advanced one stage", drive, 8'h2D);
    endtask

    task automatic test_clear_override();
        oe_n = 1'b0;
        shift_byte(8'h5A);
        pulse_latch();
        #1 clear_n = 1'b0;
        #1;
        check("R3 clear zeroes drive at once", drive, 8'h00);
        pulse_shift(1'b1);
        pulse_shift(1'b1);
        #HALF latch_clk = 1'b1;
        #HALF latch_clk = 1'b0;
        #1;
        check("R3 clock during clear ignored", drive, 8'h00);
        clear_n = 1'b1;
        #1;
        pulse_latch();
        check("R3 chain was cleared", drive, 8'h00);
        check("R3 cascade cleared", {7'b0, cascade_out}, 8'h00);
    endtask

    task automatic test_chain(input logic [15:0] stream);
        do_clear();
        oe_n = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            ser_in = stream[i];
            #HALF shift_clk = 1'b1;
            #SKEW shift_clk2 = 1'b1;
            #(HALF - SKEW) shift_clk = 1'b0;
            #SKEW shift_clk2 = 1'b0;
            #(HALF - SKEW);
        end
        pulse_latch();
        check("R8 downstream holds first byte", drive2, stream[15:8]);
        check("R8 upstream holds last byte", drive, stream[7:0]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        shift_clk = 1'b0; shift_clk2 = 1'b0; latch_clk = 1'b0;
        clear_n = 1'b0; oe_n = 1'b1; ser_in = 1'b0;
        #(CLK_PERIOD * 2) clear_n = 1'b1;
        #1;
        test_reset();
        test_load(8'hA5);
        test_load(8'h3C);
        test_hold_without_latch();
        test_enable();
        test_cascade_timing();
        test_tied_clocks();
        test_clear_override();
        test_chain(16'hB46E);
        test_chain(16'h0FF1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule